// File: doc/BRIEF.md
# I2C Status and Interrupt Flag Unit

This block sits beside an I2C bus engine. The engine reports what happens on the bus through single-cycle event strobes and a few level signals. The block turns these into a read-only 8-bit status word and one interrupt request line. It decides which events are worth an interrupt. An own-address match counts only while acknowledge is enabled. A general-call match also needs general-call enable. Byte completions count only while the block is master or is an addressed slave. A stop counts only while the block is an addressed slave.

The CPU services the interrupt by reading the status word. The read returns the value the word held in that cycle, and the interrupt bit clears one cycle later. If a new qualifying event lands in the same cycle as the read, the flag stays set, so the event is not lost. The general-call, stop, arbitration-lost and addressed-slave bits are sticky. They clear when the engine signals the start of a new address phase. A stop seen while addressed also ends the addressed state.

Top module: `i2cFlagUnit`

## Requirements
- R1: A synchronous reset, active high, clears every status bit and the interrupt request to 0 on the next clock edge.
- R2: An own-address strobe with acknowledge-enable at 1 sets the interrupt bit (bit 5) and the addressed-slave bit (bit 0) on the next edge. With acknowledge-enable at 0 the strobe has no effect on the status word.
- R3: A general-call strobe sets the general-call bit (bit 7), the interrupt bit and the addressed-slave bit on the next edge, but only when general-call enable and acknowledge-enable are both 1. Otherwise it has no effect.
- R4: A byte-done strobe while the master input is 1 sets the interrupt bit, even when an arbitration-lost strobe arrives in the same cycle. An arbitration-lost strobe sets the sticky arbitration-lost bit (bit 2).
- R5: A byte-done strobe while addressed as slave (bit 0 = 1) sets the interrupt bit. A byte-done strobe while neither master nor addressed has no effect.
- R6: A stop strobe while addressed sets the stop bit (bit 6) and the interrupt bit, and clears the addressed-slave bit. A stop strobe while not addressed has no effect.
- R7: The status read strobe returns the pre-read status word in that cycle, and clears the interrupt bit on the next edge. The interrupt request output always equals bit 5.
- R8: A qualifying set event in the same cycle as a status read leaves the interrupt bit at 1.
- R9: The not-acknowledge bit (bit 1) is set by a NACK strobe and cleared by an ACK strobe. If both arrive together, set wins.
- R10: The transmit bit (bit 4) and the bus-busy bit (bit 3) show the transmit-mode and bus-busy inputs as they were one cycle earlier.
- R11: An address-phase strobe clears bits 7, 6, 2 and 0 on the next edge. A set event for the same bit in the same cycle takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evOwnAddr | input | 1 | Own slave address received (strobe) |
| evGenCall | input | 1 | General-call address received (strobe) |
| evByteDone | input | 1 | A data byte was sent or received (strobe) |
| evStop | input | 1 | Stop condition seen (strobe) |
| evArbLost | input | 1 | Arbitration lost (strobe) |
| evNack | input | 1 | Not-acknowledge seen (strobe) |
| evAck | input | 1 | Acknowledge seen (strobe) |
| addrPhase | input | 1 | A new address phase begins (strobe) |
| isMaster | input | 1 | Engine is operating as bus master (level) |
| txMode | input | 1 | Engine is transmitting (level) |
| busBusy | input | 1 | Another master holds the bus (level) |
| ackEn | input | 1 | Acknowledge enable control bit |
| gcEn | input | 1 | General-call enable control bit |
| statusRd | input | 1 | CPU reads the status word (strobe) |
| statusOut | output | 8 | Status word: 7 gcall, 6 stop, 5 irq, 4 tx, 3 busy, 2 arb lost, 1 nack, 0 addressed slave |
| irqOut | output | 1 | Interrupt request |

## Verification
The bench targets four cases.

- **Read in the same cycle as an event.** A design that lets the clear win would drop the second interrupt and leave bit 5 at 0.
- **The clear timing of a read.** The read must see the pre-clear value. A design that cleared the flag combinationally would return bit 5 as 0 to the very read that services it.
- **Gating of the address events.** Own-address and general-call strobes are driven with each combination of acknowledge-enable and general-call enable. Byte and stop strobes are driven while neither master nor addressed. A missing gate shows up as an interrupt with no cause.
- **Priority rules.** The bench drives byte-done together with arbitration-lost, NACK together with ACK, and the address-phase clear together with set events. Each of these pairs exposes a wrongly ordered priority.

// File: rtl/i2cFlagPkg.sv
package i2cFlagPkg;
  localparam int STAT_W = 8;

  // Status word bit positions (software decodes these)
  localparam int B_SLV  = 0;
  localparam int B_NACK = 1;
  localparam int B_ARB  = 2;
  localparam int B_BUSY = 3;
  localparam int B_TX   = 4;
  localparam int B_IRQ  = 5;
  localparam int B_STOP = 6;
  localparam int B_GC   = 7;

  // Sticky flag slots inside the datapath
  localparam int S_IRQ  = 0;
  localparam int S_SEL  = 1;
  localparam int S_GC   = 2;
  localparam int S_STOP = 3;
  localparam int S_ARB  = 4;
  localparam int S_NACK = 5;
  localparam int STICKY_N = 6;

  typedef struct packed {
    logic setIrq;
    logic clrIrq;
    logic setSel;
    logic clrSel;
    logic setGc;
    logic setStop;
    logic setArb;
    logic setNack;
    logic clrNack;
    logic clrPhase;
  } flagCtlT;
endpackage

// File: rtl/i2cStickyBit.sv
module i2cStickyBit #(
  parameter bit SET_WINS = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic setIn,
  input  logic clrIn,
  output logic q
);
  generate
    if (SET_WINS) begin : g_setWins
      always_ff @(posedge clk) begin
        if (rst)        q <= 1'b0;
        else if (setIn) q <= 1'b1;
        else if (clrIn) q <= 1'b0;
      end
    end else begin : g_clrWins
      always_ff @(posedge clk) begin
        if (rst)        q <= 1'b0;
        else if (clrIn) q <= 1'b0;
        else if (setIn) q <= 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/i2cFlagCtrl.sv
module i2cFlagCtrl
  import i2cFlagPkg::*;
(
  input  logic    evOwnAddr,
  input  logic    evGenCall,
  input  logic    evByteDone,
  input  logic    evStop,
  input  logic    evArbLost,
  input  logic    evNack,
  input  logic    evAck,
  input  logic    addrPhase,
  input  logic    isMaster,
  input  logic    ackEn,
  input  logic    gcEn,
  input  logic    statusRd,
  input  logic    slaveSel,
  output flagCtlT ctl
);
  logic ownOk, gcOk, byteOk, stopOk;

  always_comb begin
    // qualification of the interrupt sources
    ownOk  = evOwnAddr & ackEn;
    gcOk   = evGenCall & gcEn & ackEn;
    byteOk = evByteDone & (isMaster | slaveSel);
    stopOk = evStop & slaveSel;

    ctl          = '0;
    ctl.setIrq   = ownOk | gcOk | byteOk | stopOk;
    ctl.clrIrq   = statusRd;
    ctl.setSel   = ownOk | gcOk;
    ctl.clrSel   = stopOk | addrPhase;
    ctl.setGc    = gcOk;
    ctl.setStop  = stopOk;
    ctl.setArb   = evArbLost;
    ctl.setNack  = evNack;
    ctl.clrNack  = evAck;
    ctl.clrPhase = addrPhase;
  end
endmodule

// File: rtl/i2cFlagPath.sv
module i2cFlagPath
  import i2cFlagPkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  flagCtlT           ctl,
  input  logic              txMode,
  input  logic              busBusy,
  output logic [STAT_W-1:0] status,
  output logic              slaveSel
);
  logic [STICKY_N-1:0] setVec, clrVec, flagQ;
  logic txQ, busyQ;

  always_comb begin
    setVec = '0;
    clrVec = '0;
    setVec[S_IRQ]  = ctl.setIrq;   clrVec[S_IRQ]  = ctl.clrIrq;
    setVec[S_SEL]  = ctl.setSel;   clrVec[S_SEL]  = ctl.clrSel;
    setVec[S_GC]   = ctl.setGc;    clrVec[S_GC]   = ctl.clrPhase;
    setVec[S_STOP] = ctl.setStop;  clrVec[S_STOP] = ctl.clrPhase;
    setVec[S_ARB]  = ctl.setArb;   clrVec[S_ARB]  = ctl.clrPhase;
    setVec[S_NACK] = ctl.setNack;  clrVec[S_NACK] = ctl.clrNack;
  end

  genvar gi;
  generate
    for (gi = 0; gi < STICKY_N; gi++) begin : g_flag
      i2cStickyBit #(.SET_WINS(1'b1)) flag_i (
        .clk  (clk),
        .rst  (rst),
        .setIn(setVec[gi]),
        .clrIn(clrVec[gi]),
        .q    (flagQ[gi])
      );
    end
  endgenerate

  // level mirrors, one cycle behind the engine
  always_ff @(posedge clk) begin
    if (rst) begin
      txQ   <= 1'b0;
      busyQ <= 1'b0;
    end else begin
      txQ   <= txMode;
      busyQ <= busBusy;
    end
  end

  always_comb begin
    status         = '0;
    status[B_GC]   = flagQ[S_GC];
    status[B_STOP] = flagQ[S_STOP];
    status[B_IRQ]  = flagQ[S_IRQ];
    status[B_TX]   = txQ;
    status[B_BUSY] = busyQ;
    status[B_ARB]  = flagQ[S_ARB];
    status[B_NACK] = flagQ[S_NACK];
    status[B_SLV]  = flagQ[S_SEL];
  end

  assign slaveSel = flagQ[S_SEL];
endmodule

// File: rtl/i2cFlagUnit.sv
module i2cFlagUnit
  import i2cFlagPkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       evOwnAddr,
  input  logic       evGenCall,
  input  logic       evByteDone,
  input  logic       evStop,
  input  logic       evArbLost,
  input  logic       evNack,
  input  logic       evAck,
  input  logic       addrPhase,
  input  logic       isMaster,
  input  logic       txMode,
  input  logic       busBusy,
  input  logic       ackEn,
  input  logic       gcEn,
  input  logic       statusRd,
  output logic [7:0] statusOut,
  output logic       irqOut
);
  flagCtlT           ctl;
  logic              slaveSel;
  logic [STAT_W-1:0] status;

  i2cFlagCtrl ctrl_i (
    .evOwnAddr (evOwnAddr),
    .evGenCall (evGenCall),
    .evByteDone(evByteDone),
    .evStop    (evStop),
    .evArbLost (evArbLost),
    .evNack    (evNack),
    .evAck     (evAck),
    .addrPhase (addrPhase),
    .isMaster  (isMaster),
    .ackEn     (ackEn),
    .gcEn      (gcEn),
    .statusRd  (statusRd),
    .slaveSel  (slaveSel),
    .ctl       (ctl)
  );

  i2cFlagPath path_i (
    .clk     (clk),
    .rst     (rst),
    .ctl     (ctl),
    .txMode  (txMode),
    .busBusy (busBusy),
    .status  (status),
    .slaveSel(slaveSel)
  );

  assign statusOut = status;
  assign irqOut    = status[B_IRQ];
endmodule

// File: rtl/i2cFlagChk.sv
module i2cFlagChk (
  input logic       clk,
  input logic       rst,
  input logic       evOwnAddr,
  input logic       evGenCall,
  input logic       evByteDone,
  input logic       evStop,
  input logic       evNack,
  input logic       evAck,
  input logic       addrPhase,
  input logic       isMaster,
  input logic       txMode,
  input logic       ackEn,
  input logic       gcEn,
  input logic       statusRd,
  input logic [7:0] statusOut,
  input logic       irqOut
);
  logic anyEv;
  assign anyEv = evOwnAddr | evGenCall | evByteDone | evStop;

  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (statusOut == 8'h00 && !irqOut)); // R1
  AST_OWN_ADDR_SET: assert property (@(posedge clk) disable iff (rst)
    (evOwnAddr && ackEn) |=> (irqOut && statusOut[0])); // R2
  AST_GC_GATED: assert property (@(posedge clk) disable iff (rst)
    (evGenCall && !(gcEn && ackEn) && !addrPhase) |=> (statusOut[7] == $past(statusOut[7]))); // R3
  AST_MASTER_BYTE: assert property (@(posedge clk) disable iff (rst)
    (evByteDone && isMaster) |=> irqOut); // R4
  AST_SLAVE_BYTE: assert property (@(posedge clk) disable iff (rst)
    (evByteDone && statusOut[0]) |=> irqOut); // R5
  AST_STOP_SLAVE: assert property (@(posedge clk) disable iff (rst)
    (evStop && statusOut[0]) |=> (statusOut[6] && irqOut)); // R6
  AST_READ_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (statusRd && !anyEv) |=> !irqOut); // R7
  AST_READ_KEEP: assert property (@(posedge clk) disable iff (rst)
    (statusRd && evByteDone && isMaster) |=> irqOut); // R8
  AST_NACK_SET: assert property (@(posedge clk) disable iff (rst)
    evNack |=> statusOut[1]); // R9
  AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (evAck && !evNack) |=> !statusOut[1]); // R9
  AST_TX_MIRROR: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (statusOut[4] == $past(txMode))); // R10
  AST_PHASE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (addrPhase && !evStop) |=> !statusOut[6]); // R11
endmodule

bind i2cFlagUnit i2cFlagChk chk_i (
  .clk       (clk),
  .rst       (rst),
  .evOwnAddr (evOwnAddr),
  .evGenCall (evGenCall),
  .evByteDone(evByteDone),
  .evStop    (evStop),
  .evNack    (evNack),
  .evAck     (evAck),
  .addrPhase (addrPhase),
  .isMaster  (isMaster),
  .txMode    (txMode),
  .ackEn     (ackEn),
  .gcEn      (gcEn),
  .statusRd  (statusRd),
  .statusOut (statusOut),
  .irqOut    (irqOut)
);

// File: tb/i2cFlagUnit_tb_top.sv
`timescale 1ns/1ps
module i2cFlagUnit_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic evOwnAddr = 0, evGenCall = 0, evByteDone = 0, evStop = 0;
  logic evArbLost = 0, evNack = 0, evAck = 0, addrPhase = 0;
  logic isMaster = 0, txMode = 0, busBusy = 0, ackEn = 0, gcEn = 0, statusRd = 0;
  logic [7:0] statusOut;
  logic irqOut;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [7:0] mStat = 8'h00;

  always #5 clk = ~clk;

  i2cFlagUnit dut_i (
    .clk(clk), .rst(rst), .evOwnAddr(evOwnAddr), .evGenCall(evGenCall),
    .evByteDone(evByteDone), .evStop(evStop), .evArbLost(evArbLost),
    .evNack(evNack), .evAck(evAck), .addrPhase(addrPhase), .isMaster(isMaster),
    .txMode(txMode), .busBusy(busBusy), .ackEn(ackEn), .gcEn(gcEn),
    .statusRd(statusRd), .statusOut(statusOut), .irqOut(irqOut)
  );

  // Reference model built from the requirement list
  function automatic logic [7:0] modelNext(input logic [7:0] s);
    logic [7:0] n;
    logic ownOk, gcOk, byteOk, stopOk, sel;
    if (rst) return 8'h00;                                   // R1
    sel    = s[0];
    ownOk  = evOwnAddr & ackEn;                              // R2
    gcOk   = evGenCall & gcEn & ackEn;                       // R3
    byteOk = evByteDone & (isMaster | sel);                  // R4 R5
    stopOk = evStop & sel;                                   // R6
    n = s;
    n[5] = (ownOk | gcOk | byteOk | stopOk) ? 1'b1 : (statusRd ? 1'b0 : s[5]); // R7 R8
    n[0] = (ownOk | gcOk) ? 1'b1 : ((stopOk | addrPhase) ? 1'b0 : sel);      // R11
    n[7] = gcOk ? 1'b1 : (addrPhase ? 1'b0 : s[7]);
    n[6] = stopOk ? 1'b1 : (addrPhase ? 1'b0 : s[6]);
    n[2] = evArbLost ? 1'b1 : (addrPhase ? 1'b0 : s[2]);
    n[1] = evNack ? 1'b1 : (evAck ? 1'b0 : s[1]);            // R9
    n[4] = txMode;                                           // R10
    n[3] = busBusy;
    return n;
  endfunction

  task automatic checkVal(input string req, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %02h expected %02h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic clearEv();
    evOwnAddr = 0; evGenCall = 0; evByteDone = 0; evStop = 0;
    evArbLost = 0; evNack = 0; evAck = 0; addrPhase = 0; statusRd = 0;
  endtask

  // Apply the current inputs for one edge, then compare at the next falling edge
  task automatic cycle(input string req);
    logic [7:0] nxt;
    nxt = modelNext(mStat);
    @(posedge clk);
    @(negedge clk);
    mStat = nxt;
    checkVal(req, statusOut, mStat);
    checkVal({req, " irq"}, {7'd0, irqOut}, {7'd0, mStat[5]});
    clearEv();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: got timeout expected finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1;
    repeat (3) @(negedge clk);
    checkVal("R1 reset", statusOut, 8'h00);
    checkVal("R1 reset irq", {7'd0, irqOut}, 8'h00);
    rst = 0;
    mStat = 8'h00;

    // R2: own address gated by ackEn
    ackEn = 0; evOwnAddr = 1; cycle("R2 gated");
    checkVal("R2 no ack", statusOut, 8'h00);
    ackEn = 1; evOwnAddr = 1; cycle("R2 accept");
    checkVal("R2 accept", statusOut, 8'h21);

    // R7: read sees pre-clear value, clears next edge
    statusRd = 1;
    checkVal("R7 read value", statusOut, 8'h21);
    cycle("R7 clear");
    checkVal("R7 cleared", statusOut, 8'h01);

    // R5: byte as addressed slave
    evByteDone = 1; cycle("R5 slave byte");
    checkVal("R5 slave byte", statusOut, 8'h21);
    statusRd = 1; cycle("R7 clear2");

    // R6: stop while addressed, then stop while idle
    evStop = 1; cycle("R6 stop");
    checkVal("R6 stop", statusOut, 8'h60);
    statusRd = 1; cycle("R7 clear3");
    evStop = 1; cycle("R6 ignored");
    checkVal("R6 ignored", statusOut, 8'h40);
    evByteDone = 1; isMaster = 0; cycle("R5 ignored");
    checkVal("R5 ignored", statusOut, 8'h40);

    // R11: address phase clears sticky bits
    addrPhase = 1; cycle("R11 clear");
    checkVal("R11 clear", statusOut, 8'h00);

    // R3: general call gating
    gcEn = 0; evGenCall = 1; cycle("R3 gated");
    checkVal("R3 gated", statusOut, 8'h00);
    gcEn = 1; ackEn = 0; evGenCall = 1; cycle("R3 gated ack");
    checkVal("R3 gated ack", statusOut, 8'h00);
    ackEn = 1; evGenCall = 1; cycle("R3 accept");
    checkVal("R3 accept", statusOut, 8'hA1);
    addrPhase = 1; statusRd = 1; cycle("R11 clear2");
    checkVal("R11 clear2", statusOut, 8'h00);

    // R11 priority: set in same cycle as phase clear
    addrPhase = 1; evOwnAddr = 1; cycle("R11 set wins");
    checkVal("R11 set wins", statusOut, 8'h21);
    addrPhase = 1; statusRd = 1; cycle("R11 clear3");

    // R4: master byte with arbitration loss
    isMaster = 1; evByteDone = 1; evArbLost = 1; cycle("R4 arb byte");
    checkVal("R4 arb byte", statusOut, 8'h24);
    statusRd = 1; cycle("R7 clear4");
    checkVal("R7 clear4", statusOut, 8'h04);

    // R8: read and event in the same cycle
    statusRd = 1; evByteDone = 1; cycle("R8 keep");
    checkVal("R8 keep", statusOut, 8'h24);

    // R9: nack set, both together, ack clear
    evNack = 1; cycle("R9 set");
    checkVal("R9 set", statusOut & 8'h02, 8'h02);
    evNack = 1; evAck = 1; cycle("R9 both");
    checkVal("R9 both", statusOut & 8'h02, 8'h02);
    evAck = 1; cycle("R9 clear");
    checkVal("R9 clear", statusOut & 8'h02, 8'h00);

    // R10: level mirrors
    txMode = 1; busBusy = 1; cycle("R10 mirror");
    checkVal("R10 mirror", statusOut & 8'h18, 8'h18);
    txMode = 0; cycle("R10 tx drop");
    checkVal("R10 tx drop", statusOut & 8'h18, 8'h08);

    // Random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      evOwnAddr  = ($urandom % 10) == 0;
      evGenCall  = ($urandom % 12) == 0;
      evByteDone = ($urandom % 4) == 0;
      evStop     = ($urandom % 10) == 0;
      evArbLost  = ($urandom % 16) == 0;
      evNack     = ($urandom % 6) == 0;
      evAck      = ($urandom % 5) == 0;
      addrPhase  = ($urandom % 9) == 0;
      statusRd   = ($urandom % 3) == 0;
      isMaster   = ($urandom % 3) == 0;
      txMode     = $urandom % 2;
      busBusy    = $urandom % 2;
      ackEn      = ($urandom % 4) != 0;
      gcEn       = $urandom % 2;
      cycle("random R2 R3 R4 R5 R6 R7 R8 R9 R10 R11");
    end

    // R1: reset while events are active
    evOwnAddr = 1; ackEn = 1; evNack = 1; txMode = 1; rst = 1;
    cycle("R1 reset busy");
    checkVal("R1 reset busy", statusOut, 8'h00);
    rst = 0;

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule